// File: doc/BRIEF.md
# DDR2 Read Burst Data Sequencer

This block models the memory side of a DDR2 read data path. Each clock it samples a command strobe, a command kind and a column address. An accepted READ produces a burst of data beats a fixed read latency later. The latency is the sum of the additive latency and the CAS latency. The bus is double data rate, so the block presents two beats per clock: the earlier beat on an even lane and the later beat on an odd lane. Beat values come from the column address, so that ordering can be seen from the outside.

The burst length is 8 beats (four clocks) or 4 beats (two clocks), chosen by a mode input that is captured with each accepted READ. A plain READ that arrives exactly two clocks into an 8-beat burst cuts that burst off after its first four beats. The new burst then starts on the very next bus cycle with no idle gap and runs to full length. Such cuts can be chained. A READ that arrives at any other point of a running burst is dropped. A burst opened by a READ with auto-precharge is never cut. Other command kinds have no effect.

Top module: `rd_burst_seq`

## Requirements
- R1: During and after reset, with no command given, `dq_valid` is 0 and both data lanes are 0.
- R2: The first beat pair of an accepted READ is on the outputs RD_LAT = ADD_LAT + CAS_LAT clocks after the clock edge that samples the command (3 by default).
- R3: Beat i of a burst carries (column address + i) modulo 2^10. The even lane carries beats 0, 2, 4, 6 and the odd lane carries beats 1, 3, 5, 7, one pair per clock.
- R4: With `mode_bl8` = 1 at acceptance, an uninterrupted burst keeps `dq_valid` high for exactly 4 consecutive clocks.
- R5: With `mode_bl8` = 0 at acceptance, a burst keeps `dq_valid` high for exactly 2 consecutive clocks and is never cut.
- R6: A READ (kind 01 or 10) sampled exactly 2 clocks after the start of a cuttable 8-beat burst ends that burst after beats 0-3. The new burst's beat pair 0 follows in the next clock, and the new burst runs to its full length.
- R7: Cuts chain: each READ sampled 2 clocks after the previous accepted one cuts that burst the same way.
- R8: A READ sampled while a burst is running, other than at the cut point of R6, is ignored. The output stream is unchanged.
- R9: A burst started by a READ with auto-precharge (kind 10) is not cut; a READ 2 clocks into it is ignored. A READ with auto-precharge may itself cut a plain 8-beat burst.
- R10: Command kind encoding: 00 no-op, 01 READ, 10 READ with auto-precharge, 11 any other command. Kinds 00 and 11, and any command with `cmd_valid` = 0, have no effect on the output stream.
- R11: A READ sampled on the clock a burst issues its last pair (2 clocks after a 4-beat start, 4 clocks after an 8-beat start) is accepted, and its data follows without a gap.
- R12: When no burst is in flight, `dq_valid` is 0 and both lanes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe for this clock |
| cmd_kind | input | 2 | Command kind: 00 no-op, 01 READ, 10 READ with auto-precharge, 11 other |
| col_addr | input | 10 | Column address of the command |
| mode_bl8 | input | 1 | Burst length select: 1 for 8 beats, 0 for 4 beats |
| dq_valid | output | 1 | A beat pair is on the data lanes this clock |
| dq_even | output | 10 | Earlier beat of the pair |
| dq_odd | output | 10 | Later beat of the pair |

## Verification
The assertions check the following on every cycle:
- The two lanes always form an adjacent pair.
- Idle lanes are zero.
- Each accepted READ opens with its own column address.
- Every continued pair advances by two beats.
- The output stream is the generator's stream delayed by exactly the read latency.
- Non-read commands are never accepted.

The bench's scenarios are needed for the timing rules across commands:
- That a cut happens only at the two-clock point.
- That auto-precharge bursts resist it.
- That chained cuts and boundary-aligned READs leave no idle beat.
- That burst lengths follow the mode captured at each command.

// File: rtl/ddr2_rdseq_pkg.sv
package ddr2_rdseq_pkg;

    // column / beat value width shared by the read data path
    parameter int unsigned RD_COL_W = 10;

    typedef logic [RD_COL_W-1:0] col_t;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_RD    = 2'b01,
        CMD_RDA   = 2'b10,
        CMD_OTHER = 2'b11
    } cmd_kind_e;

    // one bus cycle worth of data: two beats plus a valid flag
    typedef struct packed {
        logic vld;
        col_t ev;
        col_t od;
    } beat_pair_t;

    localparam int unsigned PAIRS_LONG  = 4;
    localparam int unsigned PAIRS_SHORT = 2;

    function automatic logic [2:0] pairs_for(input logic long_burst);
        return long_burst ? 3'(PAIRS_LONG) : 3'(PAIRS_SHORT);
    endfunction

    // beat value for pair number idx, lane odd_lane
    function automatic col_t beat_of(input col_t base, input logic [1:0] idx,
                                     input logic odd_lane);
        return base + RD_COL_W'({idx, odd_lane});
    endfunction

endpackage

// File: rtl/rd_cmd_decode.sv
module rd_cmd_decode
    import ddr2_rdseq_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [1:0] cmd_kind,
    output logic       is_read,
    output logic       is_ap
);
    cmd_kind_e kind;

    always_comb begin
        kind    = cmd_kind_e'(cmd_kind);
        is_read = cmd_valid && (kind == CMD_RD || kind == CMD_RDA);
        is_ap   = (kind == CMD_RDA);
    end
endmodule

// File: rtl/rd_burst_gen.sv
module rd_burst_gen
    import ddr2_rdseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       is_read,
    input  logic       is_ap,
    input  col_t       col,
    input  logic       mode_bl8,
    output logic       accept,
    output beat_pair_t pair_o
);
    col_t       base_q;
    logic [1:0] idx_q;
    logic [2:0] remain_q;
    logic       ap_q;
    logic       long_q;
    logic       can_cut;

    // a running burst may be cut only at its two-clock point, long, no auto-precharge
    always_comb begin
        can_cut = (remain_q == 3'd2) && long_q && !ap_q;
        accept  = is_read && ((remain_q == 3'd0) || can_cut);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            idx_q    <= '0;
            remain_q <= '0;
            ap_q     <= 1'b0;
            long_q   <= 1'b0;
            pair_o   <= '0;
        end else if (accept) begin
            base_q   <= col;
            idx_q    <= 2'd1;
            remain_q <= pairs_for(mode_bl8) - 3'd1;
            ap_q     <= is_ap;
            long_q   <= mode_bl8;
            pair_o   <= '{vld: 1'b1, ev: beat_of(col, 2'd0, 1'b0),
                          od: beat_of(col, 2'd0, 1'b1)};
        end else if (remain_q != 3'd0) begin
            idx_q    <= idx_q + 2'd1;
            remain_q <= remain_q - 3'd1;
            pair_o   <= '{vld: 1'b1, ev: beat_of(base_q, idx_q, 1'b0),
                          od: beat_of(base_q, idx_q, 1'b1)};
        end else begin
            pair_o   <= '0;
        end
    end
endmodule

// File: rtl/rd_lat_pipe.sv
module rd_lat_pipe
    import ddr2_rdseq_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  beat_pair_t din,
    output beat_pair_t dout
);
    beat_pair_t st [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) st[i] <= '0;
                else     st[i] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) st[i] <= '0;
                else     st[i] <= st[i-1];
            end
        end
    end

    assign dout = st[DEPTH-1];
endmodule

// File: rtl/rd_burst_seq.sv
module rd_burst_seq
    import ddr2_rdseq_pkg::*;
#(
    parameter int unsigned CAS_LAT = 3,
    parameter int unsigned ADD_LAT = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_kind,
    input  logic [RD_COL_W-1:0] col_addr,
    input  logic                mode_bl8,
    output logic                dq_valid,
    output logic [RD_COL_W-1:0] dq_even,
    output logic [RD_COL_W-1:0] dq_odd
);
    localparam int unsigned RD_LAT = CAS_LAT + ADD_LAT;

    logic       rd_hit;
    logic       rd_ap;
    logic       acc;
    beat_pair_t gen_pair;
    beat_pair_t out_pair;

    rd_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .is_read   (rd_hit),
        .is_ap     (rd_ap)
    );

    rd_burst_gen u_gen (
        .clk      (clk),
        .rst      (rst),
        .is_read  (rd_hit),
        .is_ap    (rd_ap),
        .col      (col_addr),
        .mode_bl8 (mode_bl8),
        .accept   (acc),
        .pair_o   (gen_pair)
    );

    rd_lat_pipe #(.DEPTH(RD_LAT)) u_pipe (
        .clk  (clk),
        .rst  (rst),
        .din  (gen_pair),
        .dout (out_pair)
    );

    assign dq_valid = out_pair.vld;
    assign dq_even  = out_pair.ev;
    assign dq_odd   = out_pair.od;
endmodule

// File: rtl/rd_burst_seq_chk.sv
module rd_burst_seq_chk
    import ddr2_rdseq_pkg::*;
#(
    parameter int unsigned RD_LAT = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [1:0] cmd_kind,
    input col_t       col_addr,
    input logic       acc,
    input logic       gen_vld,
    input col_t       gen_ev,
    input logic       dq_valid,
    input col_t       dq_even,
    input col_t       dq_odd
);
    logic [RD_LAT-1:0] vld_sh;

    always_ff @(posedge clk) begin
        if (rst) vld_sh <= '0;
        else begin
            vld_sh[0] <= gen_vld;
            for (int i = 1; i < RD_LAT; i++) vld_sh[i] <= vld_sh[i-1];
        end
    end

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !dq_valid |-> (dq_even == '0 && dq_odd == '0));

    // R3
    lane_pair_chk: assert property (@(posedge clk) disable iff (rst)
        dq_valid |-> (dq_odd == col_t'(dq_even + col_t'(1))));

    // R3
    start_value_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> (gen_vld && gen_ev == $past(col_addr)));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_vld && !$past(acc)) |-> ($past(gen_vld) && gen_ev == col_t'($past(gen_ev) + col_t'(2))));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        dq_valid == vld_sh[RD_LAT-1]);

    // R10
    no_read_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && (cmd_kind == 2'b01 || cmd_kind == 2'b10)) |-> !acc);
endmodule

bind rd_burst_seq rd_burst_seq_chk #(.RD_LAT(RD_LAT)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .col_addr  (col_addr),
    .acc       (acc),
    .gen_vld   (gen_pair.vld),
    .gen_ev    (gen_pair.ev),
    .dq_valid  (dq_valid),
    .dq_even   (dq_even),
    .dq_odd    (dq_odd)
);

// File: tb/rd_burst_seq_tb.sv
module rd_burst_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CL   = 3;
    localparam int AL   = 0;
    localparam int RL   = CL + AL;
    localparam int MAXC = 1024;
    localparam int MASK = 1023;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_kind = 2'b00;
    logic [9:0] col_addr = '0;
    logic       mode_bl8 = 1'b1;
    logic       dq_valid;
    logic [9:0] dq_even, dq_odd;

    rd_burst_seq #(.CAS_LAT(CL), .ADD_LAT(AL)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .col_addr(col_addr), .mode_bl8(mode_bl8),
        .dq_valid(dq_valid), .dq_even(dq_even), .dq_odd(dq_odd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";
    bit    exp_v  [MAXC];
    int    exp_ev [MAXC];

    // model of the burst that was accepted last
    int m_start = -100;
    int m_pairs = 0;
    bit m_ap = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // compare against the reference every cycle, away from the active edge
    always @(negedge clk) begin
        if (cyc >= 1 && cyc < MAXC && !done) begin
            int ee, eo;
            ee = exp_v[cyc] ? exp_ev[cyc] : 0;
            eo = exp_v[cyc] ? ((exp_ev[cyc] + 1) & MASK) : 0;
            n_chk++;
            if (dq_valid !== exp_v[cyc] || dq_even !== 10'(ee) || dq_odd !== 10'(eo)) begin
                n_bad++;
                $display("FAIL %s cycle %0d: got vld=%0b ev=%0d od=%0d, expected vld=%0b ev=%0d od=%0d",
                         cur_req, cyc, dq_valid, dq_even, dq_odd, exp_v[cyc], ee, eo);
            end
        end
    end

    // drive one command for the coming edge and update the model, then advance
    task automatic cmd(input bit v, input bit [1:0] k, input int c);
        int p;
        p = cyc + 1;
        cmd_valid = v;
        cmd_kind  = k;
        col_addr  = 10'(c);
        if (v && (k == 2'b01 || k == 2'b10)) begin
            if (p >= m_start + m_pairs || (m_pairs == 4 && !m_ap && p == m_start + 2)) begin
                int np;
                np = mode_bl8 ? 4 : 2;
                for (int j = 0; j < np; j++) begin
                    if (p + RL + j < MAXC) begin
                        exp_v[p + RL + j]  = 1'b1;
                        exp_ev[p + RL + j] = (c + 2 * j) & MASK;
                    end
                end
                m_start = p;
                m_pairs = np;
                m_ap    = (k == 2'b10);
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cmd(0, 2'b00, 0);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        idle(4);
        rst = 1'b0;
        idle(4);

        // R2 / R4: single long burst, latency and length
        cur_req = "R2";
        mode_bl8 = 1'b1;
        cmd(1, 2'b01, 10);
        cur_req = "R4";
        idle(9);

        // R5: short burst
        cur_req = "R5";
        mode_bl8 = 1'b0;
        cmd(1, 2'b01, 20);
        idle(8);

        // R6: one cut at the two-clock point
        cur_req = "R6";
        mode_bl8 = 1'b1;
        cmd(1, 2'b01, 100);
        cmd(0, 2'b00, 0);
        cmd(1, 2'b01, 200);
        idle(9);

        // R7: chained cuts
        cur_req = "R7";
        cmd(1, 2'b01, 300); cmd(0, 2'b00, 0);
        cmd(1, 2'b01, 310); cmd(0, 2'b00, 0);
        cmd(1, 2'b01, 320); cmd(0, 2'b00, 0);
        cmd(1, 2'b01, 330);
        idle(9);

        // R8: READs at non-cut points are dropped
        cur_req = "R8";
        cmd(1, 2'b01, 400);
        cmd(1, 2'b01, 500);
        cmd(0, 2'b00, 0);
        cmd(1, 2'b01, 600);
        idle(9);
        mode_bl8 = 1'b0;
        cmd(1, 2'b01, 40);
        cmd(1, 2'b01, 50);
        idle(8);

        // R9: auto-precharge bursts are not cut, but may cut
        cur_req = "R9";
        mode_bl8 = 1'b1;
        cmd(1, 2'b10, 700);
        cmd(0, 2'b00, 0);
        cmd(1, 2'b01, 800);
        idle(9);
        cmd(1, 2'b01, 900);
        cmd(0, 2'b00, 0);
        cmd(1, 2'b10, 950);
        cmd(0, 2'b00, 0);
        cmd(1, 2'b01, 960);
        idle(9);

        // R10: strobe low, no-op and other commands have no effect
        cur_req = "R10";
        cmd(0, 2'b01, 111);
        cmd(1, 2'b11, 222);
        cmd(1, 2'b00, 333);
        idle(6);
        cmd(1, 2'b01, 140);
        cmd(0, 2'b00, 0);
        cmd(1, 2'b11, 150);
        cmd(0, 2'b01, 160);
        idle(9);

        // R11: READs on the last-issue clock follow without a gap
        cur_req = "R11";
        mode_bl8 = 1'b0;
        cmd(1, 2'b01, 60);  cmd(0, 2'b00, 0);
        cmd(1, 2'b01, 70);  cmd(0, 2'b00, 0);
        cmd(1, 2'b01, 80);
        idle(8);
        mode_bl8 = 1'b1;
        cmd(1, 2'b01, 500); idle(3);
        cmd(1, 2'b01, 520);
        idle(9);

        // R3: beat values wrap around the column width
        cur_req = "R3";
        cmd(1, 2'b01, 1020);
        idle(9);

        cur_req = "R12";
        idle(5);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule